// File: doc/BRIEF.md
# NAND Cache Read Sequencer

This block runs one continuous cache-read session against a parallel NAND flash, driven from the host side. A single request gives a start row, a choice of four or five address cycles, a page count and a timeout limit. The sequencer then drives the 8-bit flash bus: command and address latch enables, write and read strobes, and the output enable of the data bus. It sends the read setup, the address, the cache-read confirm and finally the exit command. It waits through the device's initial busy time and reads each page byte by byte. Every byte is passed to a valid/ready stream.

The device fetches the next page internally while the host is still reading the current one. Between pages the sequencer polls the flash status register until the cache-ready bit is set. It then returns the device to data output and reads the next page. After the last requested page it sends the exit command straight away. Any prefetch still running inside the device is abandoned, and its data is never read.

A busy line that stays low, or a status poll that never shows the cache as ready, counts as a timeout. The sequencer then raises an error flag and closes the session with the exit command.

Top module: `nand_cache_rd_seq`

## Requirements
- R1: A start request with a nonzero page count while idle sends command 00h (command latch high, address latch low). It then sends address cycles with address latch high and command latch low: 4 cycles when `cmd_five_cyc`=0, 5 when it is 1. The first two address bytes are 00h, followed by the row bytes, least significant byte first.
- R2: Right after the last address cycle, one command cycle carries 31h.
- R3: After the confirm, no read strobe occurs while the ready line is low. If the ready line has not gone high within `cmd_tmo` cycles, `err` is set and 34h is sent.
- R4: Each page takes exactly PAGE_BYTES read strobes. Its bytes appear on the output stream in column order, starting at column 0 of row `cmd_row`+k for page k.
- R5: Between pages, the block sends command 70h and then reads status bytes until bit 6 (cache ready) is 1. It then sends command 00h and reads the next page. It never resumes while bit 6 is 0.
- R6: After the final byte of the final page, command 34h follows with no status poll. No byte beyond the requested pages is read or delivered.
- R7: `out_last` is high only with the final byte of the final requested page. It is never high in a session that ends in error.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold, and no byte is lost or repeated.
- R9: If bit 6 is still 0 when a status read completes more than `cmd_tmo` cycles after polling began, `err` is set, 34h is sent and no further page is read.
- R10: After reset both strobes are high, both latch enables are low, the bus is not driven, and `out_valid` and `busy` are low.
- R11: A start request is ignored while `busy` is high, or when `cmd_pages` is zero.
- R12: The write and read strobes are never low together, and the two latch enables are never high together. While `busy` is low neither strobe is low and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request pulse |
| cmd_row | input | ROW_W | Start row address |
| cmd_five_cyc | input | 1 | 1 = five address cycles, 0 = four |
| cmd_pages | input | CNT_W | Number of pages to read |
| cmd_tmo | input | TMO_W | Timeout limit in clock cycles |
| busy | output | 1 | Session in progress |
| err | output | 1 | Last session ended by timeout |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_last | output | 1 | Final byte of the session |
| out_ready | input | 1 | Stream consumer ready |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus value driven to flash |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_i | input | 8 | Bus value from flash |
| nf_rb | input | 1 | Ready (high) / busy (low) |

## Verification
The bench models the flash behaviourally. Its prefetch time is programmable, and the cache-ready bit only goes high once the prefetch has finished. A sequencer that resumes too early therefore reads a wrong page, and the model also counts each early resume. A single-page session with a long prefetch exposes a design that polls before exit or reads into page n+1. Both ends of the address-cycle option are covered; a wrong cycle count or byte order shows up as bad address bytes. Random backpressure exposes a dropped or repeated byte, stuck busy and stuck cache-ready exercise both timeout paths, and a start pulse mid-session shows up as a second confirm command.

// File: rtl/ncs_pkg.sv
package ncs_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_READ} cyc_e;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONF, S_WB, S_RB,
    S_RD, S_STAT, S_POLL, S_RESUME, S_EXIT
  } st_e;
  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_CACHE  = 8'h31;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_EXIT   = 8'h34;
  localparam int SR_CACHE_RDY = 6;
endpackage

// File: rtl/ncs_bus_phy.sv
// One flash bus cycle: strobe low for one clock, then high; latch
// enables and bus drive are released one clock after the strobe rises.
module ncs_bus_phy
  import ncs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  cyc_e       kind,
  input  logic [7:0] wbyte,
  output logic       idle,
  output logic       done,
  output logic [7:0] rbyte,
  output logic       nf_cle,
  output logic       nf_ale,
  output logic       nf_we_n,
  output logic       nf_re_n,
  output logic [7:0] nf_dq_o,
  output logic       nf_dq_oe,
  input  logic [7:0] nf_dq_i
);
  logic low;
  assign idle = !low;

  always_ff @(posedge clk) begin
    if (rst) begin
      low      <= 1'b0;
      done     <= 1'b0;
      rbyte    <= '0;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_we_n  <= 1'b1;
      nf_re_n  <= 1'b1;
      nf_dq_o  <= '0;
      nf_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!low && req) begin
        low      <= 1'b1;
        nf_cle   <= (kind == CYC_CMD);
        nf_ale   <= (kind == CYC_ADDR);
        nf_dq_oe <= (kind != CYC_READ);
        nf_dq_o  <= wbyte;
        nf_we_n  <= (kind == CYC_READ);
        nf_re_n  <= (kind != CYC_READ);
      end else if (low) begin
        low     <= 1'b0;
        done    <= 1'b1;
        nf_we_n <= 1'b1;
        nf_re_n <= 1'b1;
        if (!nf_re_n) rbyte <= nf_dq_i;
      end else if (done) begin
        nf_cle   <= 1'b0;
        nf_ale   <= 1'b0;
        nf_dq_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ncs_timer.sv
// Saturating cycle counter, cleared on state entry.
module ncs_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nand_cache_rd_seq.sv
module nand_cache_rd_seq
  import ncs_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int ROW_W      = 24,
  parameter int CNT_W      = 16,
  parameter int TMO_W      = 20,
  parameter int WB_CYC     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             cmd_five_cyc,
  input  logic [CNT_W-1:0] cmd_pages,
  input  logic [TMO_W-1:0] cmd_tmo,
  output logic             busy,
  output logic             err,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_last,
  input  logic             out_ready,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_rb
);
  localparam int BC_W = (PAGE_BYTES > 2) ? $clog2(PAGE_BYTES) : 1;
  localparam logic [BC_W-1:0] LAST_COL = BC_W'(PAGE_BYTES - 1);

  st_e              st_q, st_prev;
  logic [ROW_W-1:0] row_q;
  logic             five_q;
  logic [CNT_W-1:0] pg_left;
  logic [TMO_W-1:0] tmo_q;
  logic [2:0]       a_idx;
  logic [BC_W-1:0]  b_idx;
  logic             rb_s1, rb_q;

  logic       phy_req, phy_idle, phy_done, want;
  cyc_e       phy_kind;
  logic [7:0] phy_byte, phy_rbyte;

  logic             tmr_clr;
  logic [TMO_W-1:0] tmr_cnt;
  logic             expired, last_byte, slot_free;

  assign tmr_clr   = (st_q != st_prev);
  assign expired   = !tmr_clr && (tmr_cnt >= tmo_q);
  assign last_byte = (b_idx == LAST_COL);
  assign slot_free = !out_valid || out_ready;

  ncs_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(tmr_cnt)
  );

  ncs_bus_phy u_phy (
    .clk(clk), .rst(rst), .req(phy_req), .kind(phy_kind), .wbyte(phy_byte),
    .idle(phy_idle), .done(phy_done), .rbyte(phy_rbyte),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i)
  );

  // Bus cycle wanted by the current state
  always_comb begin
    phy_kind = CYC_CMD;
    phy_byte = OP_READ;
    want     = 1'b0;
    case (st_q)
      S_SETUP:  want = 1'b1;
      S_ADDR: begin
        phy_kind = CYC_ADDR;
        want     = 1'b1;
        phy_byte = (a_idx < 3'd2) ? 8'h00 : 8'(row_q >> {a_idx - 3'd2, 3'b000});
      end
      S_CONF:   begin want = 1'b1; phy_byte = OP_CACHE; end
      S_RD:     begin want = slot_free; phy_kind = CYC_READ; end
      S_STAT:   begin want = 1'b1; phy_byte = OP_STATUS; end
      S_POLL:   begin want = 1'b1; phy_kind = CYC_READ; end
      S_RESUME: want = 1'b1;
      S_EXIT:   begin want = 1'b1; phy_byte = OP_EXIT; end
      default:  want = 1'b0;
    endcase
  end
  assign phy_req = want && phy_idle && !phy_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      st_prev   <= S_IDLE;
      row_q     <= '0;
      five_q    <= 1'b0;
      pg_left   <= '0;
      tmo_q     <= '0;
      a_idx     <= '0;
      b_idx     <= '0;
      rb_s1     <= 1'b1;
      rb_q      <= 1'b1;
      busy      <= 1'b0;
      err       <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      st_prev <= st_q;
      rb_s1   <= nf_rb;
      rb_q    <= rb_s1;
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      case (st_q)
        S_IDLE: if (cmd_start && cmd_pages != '0) begin
          row_q   <= cmd_row;
          five_q  <= cmd_five_cyc;
          pg_left <= cmd_pages;
          tmo_q   <= cmd_tmo;
          a_idx   <= '0;
          busy    <= 1'b1;
          err     <= 1'b0;
          st_q    <= S_SETUP;
        end
        S_SETUP: if (phy_done) st_q <= S_ADDR;
        S_ADDR: if (phy_done) begin
          if (a_idx == (five_q ? 3'd4 : 3'd3)) st_q <= S_CONF;
          else a_idx <= a_idx + 3'd1;
        end
        S_CONF: if (phy_done) st_q <= S_WB;
        S_WB: if (!tmr_clr && tmr_cnt >= TMO_W'(WB_CYC)) st_q <= S_RB;
        S_RB: begin
          if (rb_q) begin
            b_idx <= '0;
            st_q  <= S_RD;
          end else if (expired) begin
            err  <= 1'b1;
            st_q <= S_EXIT;
          end
        end
        S_RD: if (phy_done) begin
          out_valid <= 1'b1;
          out_data  <= phy_rbyte;
          out_last  <= last_byte && (pg_left == CNT_W'(1));
          b_idx     <= last_byte ? '0 : b_idx + 1'b1;
          if (last_byte) begin
            if (pg_left == CNT_W'(1)) st_q <= S_EXIT;
            else begin
              pg_left <= pg_left - 1'b1;
              st_q    <= S_STAT;
            end
          end
        end
        S_STAT: if (phy_done) st_q <= S_POLL;
        S_POLL: if (phy_done) begin
          if (phy_rbyte[SR_CACHE_RDY]) st_q <= S_RESUME;
          else if (expired) begin
            err  <= 1'b1;
            st_q <= S_EXIT;
          end
        end
        S_RESUME: if (phy_done) begin
          b_idx <= '0;
          st_q  <= S_RD;
        end
        S_EXIT: if (phy_done) begin
          busy <= 1'b0;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ncs_chk.sv
module ncs_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_dq_oe,
  input logic       nf_rb
);
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n));

  a_r12_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (nf_we_n && nf_re_n && !nf_dq_oe));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r3_no_read_busy: assert property (@(posedge clk) disable iff (rst)
    !nf_rb |-> nf_re_n);

  a_r4_read_undriven: assert property (@(posedge clk) disable iff (rst)
    !nf_re_n |-> !nf_dq_oe);
endmodule

bind nand_cache_rd_seq ncs_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe), .nf_rb(nf_rb)
);

// File: tb/tb_nand_cache_rd_seq.sv
`timescale 1ns/1ps
module tb_nand_cache_rd_seq;
  localparam int PB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [23:0] cmd_row = '0;
  logic        cmd_five = 1'b0;
  logic [15:0] cmd_pages = '0;
  logic [19:0] cmd_tmo = '0;
  logic        out_ready = 1'b1;
  logic        nf_rb = 1'b1;
  logic [7:0]  nf_dq_i = '0;
  logic        busy, err, out_valid, out_last;
  logic [7:0]  out_data, nf_dq_o;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;

  always #4 clk = ~clk;

  nand_cache_rd_seq #(.PAGE_BYTES(PB), .ROW_W(24), .CNT_W(16), .TMO_W(20), .WB_CYC(4)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_row(cmd_row),
    .cmd_five_cyc(cmd_five), .cmd_pages(cmd_pages), .cmd_tmo(cmd_tmo),
    .busy(busy), .err(err), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pdata(input int row, input int col);
    return 8'(row * 13 + col * 5 + 90);
  endfunction

  // Behavioural flash model and stream reference
  int m_mode = 0, m_nadr = 0, m_busy_left = 0, m_pf_left = 0, m_row = 0, m_col = 0;
  bit m_stat = 0;
  logic [7:0] m_addr [0:7];
  logic [7:0] cmd_log[$];
  logic [7:0] exp_q[$];
  int early = 0, rd_busy = 0, overread = 0, extra = 0, last_cnt = 0, viol = 0;
  int cfg_busy = 10, cfg_pf = 0, stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    logic nr;
    logic [7:0] e;
    if (!rst) begin
      nr = (stall_mode != 0) ? lfsr[0] : 1'b1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= nr;
      if (out_valid && nr) begin
        if (exp_q.size() == 0) extra++;
        else begin
          e = exp_q.pop_front();
          chk(out_data == e, "R4 byte", int'(out_data), int'(e));
          chk(out_last == (exp_q.size() == 0 && stall_mode >= 0 && m_mode >= 0 && last_ok()),
              "R7 last flag", int'(out_last), int'(exp_q.size() == 0 && last_ok()));
        end
        if (out_last) last_cnt++;
      end
      if ((!nf_we_n && !nf_re_n) || (nf_cle && nf_ale)) viol++;
      if (!nf_we_n) begin
        if (nf_cle) begin
          cmd_log.push_back(nf_dq_o);
          case (nf_dq_o)
            8'h00: if (m_mode == 3) begin
              m_stat = 0;
              if (m_pf_left > 0) early++;
              m_row++;
              m_col = 0;
              m_pf_left = cfg_pf;
            end else begin
              m_mode = 1;
              m_nadr = 0;
            end
            8'h31: if (m_mode == 1) begin
              m_mode = 3;
              m_stat = 0;
              m_col = 0;
              m_row = (m_nadr == 5) ? int'({m_addr[4], m_addr[3], m_addr[2]})
                                    : int'({m_addr[3], m_addr[2]});
              nf_rb <= 1'b0;
              m_busy_left = cfg_busy;
              m_pf_left = cfg_pf;
            end
            8'h70: m_stat = 1;
            8'h34: begin
              m_mode = 0;
              m_stat = 0;
              m_busy_left = 0;
              nf_rb <= 1'b1;
            end
            default: ;
          endcase
        end else if (nf_ale) begin
          if (m_nadr < 8) m_addr[m_nadr] = nf_dq_o;
          m_nadr++;
        end
      end
      if (!nf_re_n) begin
        if (!nf_rb) rd_busy++;
        if (m_stat) nf_dq_i <= (m_pf_left == 0) ? 8'h60 : 8'h00;
        else begin
          if (m_col >= PB) overread++;
          nf_dq_i <= pdata(m_row, m_col);
          m_col++;
        end
      end
      if (m_busy_left > 0) begin
        m_busy_left--;
        if (m_busy_left == 0) nf_rb <= 1'b1;
      end else if (m_mode == 3 && m_pf_left > 0) m_pf_left--;
    end
  end

  bit sess_err_exp = 0;
  function automatic bit last_ok();
    return !sess_err_exp;
  endfunction

  task automatic run(input logic [23:0] row, input bit five, input int pages,
                     input int tmo, input int bsy, input int pf, input int stall,
                     input bit exp_err, input int pages_out, input bit inject);
    logic [7:0] ec[$];
    int cyc;
    @(posedge clk); #2;
    cmd_log.delete(); exp_q.delete();
    early = 0; rd_busy = 0; overread = 0; extra = 0; last_cnt = 0; viol = 0;
    cfg_busy = bsy; cfg_pf = pf; stall_mode = stall; sess_err_exp = exp_err;
    for (int p = 0; p < pages_out; p++)
      for (int c = 0; c < PB; c++) exp_q.push_back(pdata(int'(row) + p, c));
    ec.push_back(8'h00); ec.push_back(8'h31);
    for (int p = 1; p < pages_out; p++) begin ec.push_back(8'h70); ec.push_back(8'h00); end
    if (exp_err && pages_out > 0 && pages_out < pages) ec.push_back(8'h70);
    ec.push_back(8'h34);
    cmd_row = row; cmd_five = five; cmd_pages = 16'(pages); cmd_tmo = 20'(tmo);
    cmd_start = 1'b1;
    @(posedge clk); #2;
    cmd_start = 1'b0;
    cyc = 0;
    while (busy && cyc < 60000) begin
      @(posedge clk); #2;
      cyc++;
      if (inject && cyc == 50) begin cmd_start = 1'b1; cmd_row = 24'h777777; end
      else cmd_start = 1'b0;
    end
    chk(cyc < 60000, "R6 session ends", cyc, 60000);
    repeat (40) @(posedge clk);
    #2;
    chk(err == exp_err, "R3 R9 err flag", int'(err), int'(exp_err));
    chk(exp_q.size() == 0, "R4 bytes missing", exp_q.size(), 0);
    chk(extra == 0, "R6 extra bytes", extra, 0);
    chk(overread == 0, "R6 reads past page", overread, 0);
    chk(last_cnt == (exp_err ? 0 : 1), "R7 last count", last_cnt, exp_err ? 0 : 1);
    chk(early == 0, "R5 resume before cache ready", early, 0);
    chk(rd_busy == 0, "R3 read while busy", rd_busy, 0);
    chk(viol == 0, "R12 strobe/latch overlap", viol, 0);
    chk(cmd_log.size() == ec.size(), "R2 R5 R6 command count", cmd_log.size(), ec.size());
    for (int i = 0; i < ec.size() && i < cmd_log.size(); i++)
      chk(cmd_log[i] == ec[i], "R2 R5 R6 command code", int'(cmd_log[i]), int'(ec[i]));
    chk(m_nadr == (five ? 5 : 4), "R1 address cycles", m_nadr, five ? 5 : 4);
    chk(m_addr[0] == 8'h00 && m_addr[1] == 8'h00, "R1 column zero",
        int'({m_addr[1], m_addr[0]}), 0);
    chk(m_addr[2] == row[7:0] && m_addr[3] == row[15:8], "R1 row bytes",
        int'({m_addr[3], m_addr[2]}), int'(row[15:0]));
    if (five) chk(m_addr[4] == row[23:16], "R1 row high byte", int'(m_addr[4]), int'(row[23:16]));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe && !out_valid && !busy,
        "R10 reset state", int'({nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe, out_valid, busy}), 7'b1100000);
    // R11: zero page count is ignored
    cmd_pages = '0; cmd_start = 1'b1;
    @(posedge clk); #2 cmd_start = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    chk(!busy && cmd_log.size() == 0, "R11 zero pages ignored", cmd_log.size(), 0);
    // Three pages, four address cycles, slow prefetch forces polling
    run(24'h000123, 1'b0, 3, 1000, 20, 120, 0, 1'b0, 3, 1'b0);
    // Two pages, five address cycles, backpressure, start injected mid-session (R8, R11)
    run(24'h0A0B0C, 1'b1, 2, 1000, 10, 0, 1, 1'b0, 2, 1'b1);
    // One page, prefetch still running at exit (R6)
    run(24'h000040, 1'b0, 1, 1000, 12, 500, 1, 1'b0, 1, 1'b0);
    // Busy never clears: timeout (R3)
    run(24'h000200, 1'b0, 2, 200, 1000000, 0, 0, 1'b1, 0, 1'b0);
    // Cache never ready: poll timeout after first page (R9)
    run(24'h000300, 1'b1, 2, 300, 10, 1000000, 0, 1'b1, 1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule